// File: doc/BRIEF.md
# UART FIFO Level Interrupt Trigger

This block generates the raw receive and raw transmit interrupt bits of a UART whose FIFOs hold 16 entries. It watches the fill counts that the two FIFOs report. It compares each count against a trigger point chosen separately for each direction from five fractions of the depth. Each raw bit is set on the cycle after its condition becomes true. Software clears a raw bit with a one-cycle write-1-to-clear pulse. The receive bit also drops by itself once reads bring the fill back under the trigger point.

The transmit side has a second mode, end-of-transmission. In this mode it ignores the level and fires once the transmit FIFO is empty and the serializer reports idle, which means the last bit of queued data has gone out. When the FIFOs are turned off, each direction acts as a single-byte holding register. In that case the block derives its conditions and its empty and full indications from whether that byte is occupied. The FIFOs, the serializer and the register decoding are outside this block. The level selections are written through a one-cycle strobe and kept here.

Top module: `uart_fifo_lvl_irq`

## Requirements
- R1: During reset and on the first cycle after it, both raw bits are 0, and both level selections are at the half-depth code (2). A receive fill of 8 after reset therefore sets the receive raw bit.
- R2: The 3-bit level code maps to a trigger count as follows: 0 gives 2, 1 gives 4, 2 gives 8, 3 gives 12 and 4 gives 14 entries. Codes 5, 6 and 7 act as code 2 (8 entries).
- R3: With FIFOs enabled, the receive condition is fill >= trigger count. The receive raw bit is set on the cycle after the condition goes from false to true, and only on that transition. A condition that stays true does not set the bit again after it has been cleared.
- R4: The receive raw bit is 0 on the cycle after any cycle in which its condition is false.
- R5: A 1 on rx_clr clears the receive raw bit on the next cycle, and a 1 on tx_clr does the same for the transmit raw bit. If a set transition occurs in the same cycle as the clear pulse, the set takes priority and the bit ends up 1.
- R6: In level mode with FIFOs enabled, the transmit condition is fill <= trigger count. The transmit raw bit is set on the cycle after the condition becomes true. Only tx_clr clears it; it does not clear when the fill rises.
- R7: With eot_mode high, the transmit condition is transmit fill == 0 and ser_idle == 1, whatever the FIFO enable and level code are.
- R8: A cycle with cfg_wr high loads cfg_rx_sel and cfg_tx_sel into the two independent level selections. The new selections take effect from the following cycle.
- R9: With fifo_en low, the receive condition is fill != 0 and the transmit level condition is fill == 0. Each full flag is fill != 0.
- R10: With fifo_en high, each full flag is fill >= 16. In both modes, each empty flag is fill == 0. All four flags are combinational from the current inputs.
- R11: A condition that is already true when reset is released does not set its raw bit. An empty transmit FIFO out of reset leaves tx_raw at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1: 16-entry FIFOs, 0: single-byte holding registers |
| rx_count | input | 5 | Receive fill count, 0 to 16 |
| tx_count | input | 5 | Transmit fill count, 0 to 16 |
| cfg_wr | input | 1 | Load strobe for both level selections |
| cfg_rx_sel | input | 3 | Receive level code to load |
| cfg_tx_sel | input | 3 | Transmit level code to load |
| eot_mode | input | 1 | Transmit fires on end of transmission instead of level |
| ser_idle | input | 1 | Serializer has shifted out its last bit |
| rx_clr | input | 1 | Write-1-to-clear pulse for the receive raw bit |
| tx_clr | input | 1 | Write-1-to-clear pulse for the transmit raw bit |
| rx_raw | output | 1 | Raw receive interrupt bit |
| tx_raw | output | 1 | Raw transmit interrupt bit |
| rx_empty | output | 1 | Receive side empty |
| rx_full | output | 1 | Receive side full |
| tx_empty | output | 1 | Transmit side empty |
| tx_full | output | 1 | Transmit side full |

## Verification
The bench clears the receive bit while the fill stays at or above the trigger. A design that sets on level rather than on the transition would set the bit again on the next cycle. It sweeps all eight level codes, including the reserved ones, so a wrong fraction or a reserved code that falls through to zero would fire at the wrong fill. It lets the transmit fill rise after the bit is set, and it releases reset with an empty transmitter. A transmit bit that clears by itself, or one that fires straight out of reset, shows up in these steps. It also switches the FIFOs off and switches end-of-transmission mode on, which catches designs that keep the 16-entry thresholds or ignore the serializer.

// File: rtl/uart_lvl_pkg.sv
package uart_lvl_pkg;
  localparam int SEL_W       = 3;
  localparam int RST_SEL     = 2;   // half depth

  // trigger point in eighths of depth; reserved codes fall back to half
  function automatic int unsigned sel_eighths(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 6;
      3'd4:    return 7;
      default: return 4;
    endcase
  endfunction

  function automatic int unsigned trig_count(input logic [SEL_W-1:0] sel,
                                             input int unsigned depth);
    return (depth * sel_eighths(sel)) / 8;
  endfunction
endpackage

// File: rtl/uart_lvl_sel_reg.sv
module uart_lvl_sel_reg
  import uart_lvl_pkg::*;
#(
  parameter int W       = SEL_W,
  parameter int RST_VAL = RST_SEL
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= W'(RST_VAL);
    else if (wr) q <= din;
  end
endmodule

// File: rtl/uart_rx_lvl_cond.sv
module uart_rx_lvl_cond
  import uart_lvl_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             fifo_en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [SEL_W-1:0] sel,
  output logic             cond,
  output logic             empty,
  output logic             full
);
  int unsigned thr;
  int unsigned cnt_i;

  always_comb begin
    thr   = trig_count(sel, DEPTH);
    cnt_i = 32'(cnt);
    empty = (cnt_i == 0);
    if (fifo_en) begin
      cond = (cnt_i >= thr);
      full = (cnt_i >= DEPTH);
    end else begin
      cond = (cnt_i != 0);   // holding byte occupied
      full = (cnt_i != 0);
    end
  end
endmodule

// File: rtl/uart_tx_lvl_cond.sv
module uart_tx_lvl_cond
  import uart_lvl_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             fifo_en,
  input  logic             eot_mode,
  input  logic             ser_idle,
  input  logic [CNT_W-1:0] cnt,
  input  logic [SEL_W-1:0] sel,
  output logic             cond,
  output logic             empty,
  output logic             full
);
  int unsigned thr;
  int unsigned cnt_i;

  always_comb begin
    thr   = trig_count(sel, DEPTH);
    cnt_i = 32'(cnt);
    empty = (cnt_i == 0);
    full  = fifo_en ? (cnt_i >= DEPTH) : (cnt_i != 0);
    if (eot_mode)     cond = (cnt_i == 0) && ser_idle;
    else if (fifo_en) cond = (cnt_i <= thr);
    else              cond = (cnt_i == 0);  // holding byte free
  end
endmodule

// File: rtl/uart_lvl_raw_bit.sv
module uart_lvl_raw_bit #(
  parameter bit SELF_CLR = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic clr,
  output logic set_evt,
  output logic raw
);
  logic cond_q;

  // cond_q resets to 1 so a condition present at reset release is no edge
  assign set_evt = cond && !cond_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_q <= 1'b1;
      raw    <= 1'b0;
    end else begin
      cond_q <= cond;
      if (set_evt)                     raw <= 1'b1;
      else if (clr || (SELF_CLR && !cond)) raw <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_fifo_lvl_irq.sv
module uart_fifo_lvl_irq
  import uart_lvl_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_rx_sel,
  input  logic [2:0]       cfg_tx_sel,
  input  logic             eot_mode,
  input  logic             ser_idle,
  input  logic             rx_clr,
  input  logic             tx_clr,
  output logic             rx_raw,
  output logic             tx_raw,
  output logic             rx_empty,
  output logic             rx_full,
  output logic             tx_empty,
  output logic             tx_full
);
  localparam int NDIR = 2;  // 0 = receive, 1 = transmit

  logic [SEL_W-1:0] sel_in [NDIR];
  logic [SEL_W-1:0] sel_q  [NDIR];
  logic             cond   [NDIR];
  logic             clr    [NDIR];
  logic             set_e  [NDIR];
  logic             raw    [NDIR];

  assign sel_in[0] = cfg_rx_sel;
  assign sel_in[1] = cfg_tx_sel;
  assign clr[0]    = rx_clr;
  assign clr[1]    = tx_clr;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    uart_lvl_sel_reg #(.W(SEL_W), .RST_VAL(RST_SEL)) u_sel (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .din(sel_in[d]), .q(sel_q[d])
    );
    // only the receive bit drops when its level condition goes away
    uart_lvl_raw_bit #(.SELF_CLR(d == 0)) u_raw (
      .clk(clk), .rst_n(rst_n), .cond(cond[d]), .clr(clr[d]),
      .set_evt(set_e[d]), .raw(raw[d])
    );
  end

  uart_rx_lvl_cond #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx_cond (
    .fifo_en(fifo_en), .cnt(rx_count), .sel(sel_q[0]),
    .cond(cond[0]), .empty(rx_empty), .full(rx_full)
  );

  uart_tx_lvl_cond #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx_cond (
    .fifo_en(fifo_en), .eot_mode(eot_mode), .ser_idle(ser_idle),
    .cnt(tx_count), .sel(sel_q[1]),
    .cond(cond[1]), .empty(tx_empty), .full(tx_full)
  );

  // named internal events for the checker
  logic             rx_cond, tx_cond, rx_set, tx_set;
  logic [SEL_W-1:0] rx_sel_q, tx_sel_q;
  assign rx_cond  = cond[0];
  assign tx_cond  = cond[1];
  assign rx_set   = set_e[0];
  assign tx_set   = set_e[1];
  assign rx_sel_q = sel_q[0];
  assign tx_sel_q = sel_q[1];

  assign rx_raw = raw[0];
  assign tx_raw = raw[1];
endmodule

// File: rtl/uart_fifo_lvl_irq_chk.sv
module uart_fifo_lvl_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_cond,
  input logic       rx_set,
  input logic       tx_set,
  input logic       rx_clr,
  input logic       tx_clr,
  input logic       rx_raw,
  input logic       tx_raw,
  input logic       rx_empty,
  input logic       rx_full,
  input logic       tx_empty,
  input logic       tx_full,
  input logic       cfg_wr,
  input logic [2:0] cfg_rx_sel,
  input logic [2:0] cfg_tx_sel,
  input logic [2:0] rx_sel_q,
  input logic [2:0] tx_sel_q
);
  // R4
  rx_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_cond |=> !rx_raw);

  // R5
  rx_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_clr && !rx_set) |=> !rx_raw);

  // R5
  tx_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_clr && !tx_set) |=> !tx_raw);

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_set || tx_set) |=> ((rx_raw || !$past(rx_set)) && (tx_raw || !$past(tx_set))));

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_set && !tx_clr) |=> $stable(tx_raw));

  // R3
  rx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_raw) |-> $past(rx_set));

  // R8
  sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (rx_sel_q == $past(cfg_rx_sel) && tx_sel_q == $past(cfg_tx_sel)));

  // R10
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_full && rx_empty) && !(tx_full && tx_empty));
endmodule

bind uart_fifo_lvl_irq uart_fifo_lvl_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_cond(rx_cond),
  .rx_set(rx_set), .tx_set(tx_set), .rx_clr(rx_clr), .tx_clr(tx_clr),
  .rx_raw(rx_raw), .tx_raw(tx_raw), .rx_empty(rx_empty), .rx_full(rx_full),
  .tx_empty(tx_empty), .tx_full(tx_full), .cfg_wr(cfg_wr),
  .cfg_rx_sel(cfg_rx_sel), .cfg_tx_sel(cfg_tx_sel),
  .rx_sel_q(rx_sel_q), .tx_sel_q(tx_sel_q)
);

// File: tb/tb_uart_fifo_lvl_irq.sv
`timescale 1ns/1ps
module tb_uart_fifo_lvl_irq;
  localparam int D = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b1;
  logic [4:0] rx_count = '0, tx_count = '0;
  logic       cfg_wr = 1'b0;
  logic [2:0] cfg_rx_sel = 3'd0, cfg_tx_sel = 3'd0;
  logic       eot_mode = 1'b0, ser_idle = 1'b0;
  logic       rx_clr = 1'b0, tx_clr = 1'b0;
  logic       rx_raw, tx_raw, rx_empty, rx_full, tx_empty, tx_full;

  int n_run = 0, n_fail = 0;

  // reference state
  logic [2:0] m_rsel, m_tsel;
  logic       m_rprev, m_tprev, m_rraw, m_traw;

  always #2 clk = ~clk;

  uart_fifo_lvl_irq dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_count(rx_count),
    .tx_count(tx_count), .cfg_wr(cfg_wr), .cfg_rx_sel(cfg_rx_sel),
    .cfg_tx_sel(cfg_tx_sel), .eot_mode(eot_mode), .ser_idle(ser_idle),
    .rx_clr(rx_clr), .tx_clr(tx_clr), .rx_raw(rx_raw), .tx_raw(tx_raw),
    .rx_empty(rx_empty), .rx_full(rx_full), .tx_empty(tx_empty), .tx_full(tx_full)
  );

  function automatic int lvl_of(input logic [2:0] code);
    case (code)
      3'd0: return 2;
      3'd1: return 4;
      3'd3: return 12;
      3'd4: return 14;
      default: return 8;
    endcase
  endfunction

  function automatic logic rx_want(input logic [2:0] code);
    if (!fifo_en) return rx_count > 0;
    return int'(rx_count) >= lvl_of(code);
  endfunction

  function automatic logic tx_want(input logic [2:0] code);
    if (eot_mode) return (tx_count == 0) && ser_idle;
    if (!fifo_en) return tx_count == 0;
    return int'(tx_count) <= lvl_of(code);
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_rsel = 3'd2; m_tsel = 3'd2;
    m_rprev = 1'b1; m_tprev = 1'b1; m_rraw = 1'b0; m_traw = 1'b0;
  endtask

  // one clock: inputs already driven; advance model, check after the edge
  task automatic step(input string tag);
    logic rc, tc;
    string rt, tt, ft;
    rc = rx_want(m_rsel);
    tc = tx_want(m_tsel);
    if (rc && !m_rprev)          m_rraw = 1'b1;
    else if (rx_clr || !rc)      m_rraw = 1'b0;
    if (tc && !m_tprev)          m_traw = 1'b1;
    else if (tx_clr)             m_traw = 1'b0;
    m_rprev = rc; m_tprev = tc;
    if (cfg_wr) begin m_rsel = cfg_rx_sel; m_tsel = cfg_tx_sel; end
    rt = (tag != "") ? tag : (fifo_en ? "R3" : "R9");
    tt = (tag != "") ? tag : (eot_mode ? "R7" : (fifo_en ? "R6" : "R9"));
    ft = fifo_en ? "R10" : "R9";
    @(posedge clk); #1;
    check(rt, "rx_raw", rx_raw, m_rraw);
    check(tt, "tx_raw", tx_raw, m_traw);
    check(ft, "rx_empty", rx_empty, rx_count == 0);
    check(ft, "tx_empty", tx_empty, tx_count == 0);
    check(ft, "rx_full", rx_full, fifo_en ? (rx_count >= 5'(D)) : (rx_count != 0));
    check(ft, "tx_full", tx_full, fifo_en ? (tx_count >= 5'(D)) : (tx_count != 0));
  endtask

  task automatic idle_strobes();
    cfg_wr = 1'b0; rx_clr = 1'b0; tx_clr = 1'b0;
  endtask

  function automatic logic [4:0] wander(input logic [4:0] c);
    int v;
    v = int'(c) + int'($urandom_range(4)) - 2;
    if ($urandom_range(15) == 0) v = int'($urandom_range(D));
    if (v < 0) v = 0;
    if (v > D) v = D;
    return 5'(v);
  endfunction

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    tx_count = 5'd0;
    repeat (3) @(posedge clk);
    #1;
    // R1: raw bits low during reset
    check("R1", "rx_raw in reset", rx_raw, 1'b0);
    check("R1", "tx_raw in reset", tx_raw, 1'b0);
    rst_n = 1'b1;
    // R11: empty transmitter at release must not fire
    step("R11");
    step("R11");
    // R1: default half-depth trigger
    rx_count = 5'd7; step("R1");
    rx_count = 5'd8; step("R1");
    // R4: drop below trigger
    rx_count = 5'd7; step("R4");
    // R3/R5: clear while above, must stay clear
    rx_count = 5'd9; step("R3");
    rx_clr = 1'b1; step("R5"); rx_clr = 1'b0;
    rx_count = 5'd10; step("R3");
    step("R3");
    // R5: set and clear in the same cycle, set wins
    rx_count = 5'd0; step("R4");
    rx_count = 5'd8; rx_clr = 1'b1; step("R5"); rx_clr = 1'b0;
    // R2/R8: sweep every code on both sides
    for (int code = 0; code < 8; code++) begin
      rx_count = 5'd0; tx_count = 5'd16;
      cfg_wr = 1'b1; cfg_rx_sel = 3'(code); cfg_tx_sel = 3'(code);
      step("R8"); idle_strobes();
      tx_clr = 1'b1; step("R2"); tx_clr = 1'b0;
      rx_count = 5'(lvl_of(3'(code)) - 1); step("R2");
      rx_count = 5'(lvl_of(3'(code)));     step("R2");
      tx_count = 5'(lvl_of(3'(code)) + 1); step("R2");
      tx_count = 5'(lvl_of(3'(code)));     step("R2");
      // R6: fill rising again must not clear tx
      tx_count = 5'd16; step("R6");
    end
    // R8: independent selections
    cfg_wr = 1'b1; cfg_rx_sel = 3'd0; cfg_tx_sel = 3'd4; step("R8"); idle_strobes();
    tx_clr = 1'b1; rx_count = 5'd0; step("R8"); tx_clr = 1'b0;
    rx_count = 5'd2; step("R8");
    tx_count = 5'd14; step("R8");
    // R7: end of transmission
    tx_clr = 1'b1; eot_mode = 1'b1; ser_idle = 1'b0; tx_count = 5'd3; step("R7"); tx_clr = 1'b0;
    tx_count = 5'd0; step("R7");
    ser_idle = 1'b1; step("R7");
    step("R7");
    eot_mode = 1'b0; ser_idle = 1'b0;
    // R9: FIFOs off, single holding byte
    fifo_en = 1'b0; rx_count = 5'd0; tx_count = 5'd1; tx_clr = 1'b1; step("R9"); tx_clr = 1'b0;
    rx_count = 5'd1; step("R9");
    tx_count = 5'd0; step("R9");
    rx_count = 5'd0; step("R9");
    fifo_en = 1'b1;
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      rx_count   = wander(rx_count);
      tx_count   = wander(tx_count);
      cfg_wr     = ($urandom_range(15) == 0);
      cfg_rx_sel = 3'($urandom_range(7));
      cfg_tx_sel = 3'($urandom_range(7));
      rx_clr     = ($urandom_range(7) == 0);
      tx_clr     = ($urandom_range(7) == 0);
      ser_idle   = 1'($urandom_range(1));
      if ($urandom_range(63) == 0) eot_mode = ~eot_mode;
      if ($urandom_range(99) == 0) fifo_en  = ~fifo_en;
      step("");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule